// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder/Subtractor

This block adds or subtracts two signed-digit operands of `N_DIGITS` digits each and returns a signed-digit result one digit wider. Each digit occupies two bits and takes the value −1, 0 or +1. Because every digit has its own sign, a value has many encodings. The block uses this freedom so that no carry ever travels far. Each result digit depends only on the operand digits at its own position and at the two positions directly below it. The logic depth is therefore the same for any operand width.

A single control input selects subtraction. When it is set, the second operand is negated one digit at a time by inverting both bits of each digit code, and the result is then added. The block is purely combinational. It has no clock, pipeline stage, conversion to two's complement or overflow handling.

Top module: `rbr_sd_addsub`

## Requirements
- R1: With `sub_en` low, the weighted value of `sum` (digit k weighted by 2^k, digit k at bits [2k+1:2k]) equals value(`op_a`) + value(`op_b`) for every pair of operand encodings.
- R2: With `sub_en` high, the weighted value of `sum` equals value(`op_a`) − value(`op_b`) for every pair of operand encodings.
- R3: Operand digit codes decode as 2'b00 = −1, 2'b01 = 0, 2'b10 = 0 and 2'b11 = +1. Replacing any operand digit code 2'b10 by 2'b01 leaves `sum` unchanged bit for bit.
- R4: Every result digit is encoded as 2'b00 for −1, 2'b01 for 0 and 2'b11 for +1. The code 2'b10 never appears on `sum`.
- R5: Result digit k depends only on operand digits k, k−1 and k−2. Changing operand digit j changes no result digit below j and no result digit above j+2.
- R6: Subtracting `op_b` gives the same `sum` bits as adding the digit-wise bit inversion of `op_b` with `sub_en` low.
- R7: When every digit of both operands encodes zero, every result digit is 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 2*N_DIGITS | First operand; digit k at bits [2k+1:2k] |
| op_b | input | 2*N_DIGITS | Second operand; same digit layout |
| sub_en | input | 1 | 1 selects op_a − op_b, 0 selects op_a + op_b |
| sum | output | 2*(N_DIGITS+1) | Signed-digit result; digit N_DIGITS is the most significant |

## Verification
The bound checker re-evaluates several properties whenever the inputs change. It confirms that the result value matches the sum or difference of the operand values, that the unused zero code 2'b10 never leaves the block, and that all-zero operands, or a subtraction of an operand from itself, give canonical zero digits. Some properties relate two different input vectors, so no single-cycle property can observe them. These are the transparency of the two zero codes, the equivalence between subtraction and adding the inverted operand, and the three-position locality window. The bench's sweeps show these by applying pairs of stimuli and comparing the outputs.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

   typedef logic        [1:0] digit_t;
   typedef logic signed [1:0] tri_t;

   localparam digit_t DG_NEG  = 2'b00;
   localparam digit_t DG_ZERO = 2'b01;
   localparam digit_t DG_POS  = 2'b11;

   function automatic tri_t dg_value(input digit_t d);
      case (d)
         2'b00:   return -2'sd1;
         2'b11:   return  2'sd1;
         default: return  2'sd0;
      endcase
   endfunction

   function automatic digit_t dg_encode(input tri_t v);
      case (v)
         -2'sd1:  return DG_NEG;
          2'sd1:  return DG_POS;
         default: return DG_ZERO;
      endcase
   endfunction

   function automatic logic dg_nonneg(input digit_t d);
      return d != DG_NEG;
   endfunction

endpackage

// File: rtl/rbr_negate.sv
module rbr_negate
   import rbr_pkg::*;
#(
   parameter int N_DIGITS = 8,
   localparam int W = 2 * N_DIGITS
) (
   input  logic [W-1:0] din,
   input  logic         invert,
   output logic [W-1:0] dout
);
   for (genvar k = 0; k < N_DIGITS; k++) begin : g_dig
      digit_t d;
      assign d = din[2*k +: 2];
      assign dout[2*k +: 2] = invert ? ~d : d;
   end
endmodule

// File: rtl/rbr_transfer_cell.sv
module rbr_transfer_cell
   import rbr_pkg::*;
#(
   parameter bit HAS_LOWER = 1'b1
) (
   input  digit_t dig_a,
   input  digit_t dig_b,
   input  digit_t low_a,
   input  digit_t low_b,
   output tri_t   xfer,
   output tri_t   interim
);
   logic signed [2:0] s;
   logic              low_nn;

   assign s = 3'(signed'(dg_value(dig_a))) + 3'(signed'(dg_value(dig_b)));

   if (HAS_LOWER) begin : g_low
      assign low_nn = dg_nonneg(low_a) && dg_nonneg(low_b);
   end else begin : g_base
      logic unused_low;
      assign unused_low = ^{low_a, low_b};
      assign low_nn = 1'b1;
   end

   always_comb begin
      xfer    = 2'sd0;
      interim = 2'sd0;
      case (s)
         3'sd2:  begin xfer =  2'sd1; interim = 2'sd0; end
         -3'sd2: begin xfer = -2'sd1; interim = 2'sd0; end
         3'sd1: begin
            if (low_nn) begin xfer = 2'sd1; interim = -2'sd1; end
            else        begin xfer = 2'sd0; interim =  2'sd1; end
         end
         -3'sd1: begin
            if (low_nn) begin xfer =  2'sd0; interim = -2'sd1; end
            else        begin xfer = -2'sd1; interim =  2'sd1; end
         end
         default: begin xfer = 2'sd0; interim = 2'sd0; end
      endcase
   end
endmodule

// File: rtl/rbr_combine_cell.sv
module rbr_combine_cell
   import rbr_pkg::*;
(
   input  tri_t   interim,
   input  tri_t   xfer_in,
   output digit_t dig_out
);
   logic signed [2:0] f;
   assign f = {interim[1], interim} + {xfer_in[1], xfer_in};
   assign dig_out = dg_encode(f[1:0]);
endmodule

// File: rtl/rbr_sd_addsub.sv
module rbr_sd_addsub
   import rbr_pkg::*;
#(
   parameter int N_DIGITS = 8,
   localparam int W_IN  = 2 * N_DIGITS,
   localparam int W_OUT = 2 * (N_DIGITS + 1)
) (
   input  logic [W_IN-1:0]  op_a,
   input  logic [W_IN-1:0]  op_b,
   input  logic             sub_en,
   output logic [W_OUT-1:0] sum
);
   if (N_DIGITS < 1) begin : g_bad_width
      $fatal(1, "rbr_sd_addsub: N_DIGITS must be at least 1");
   end

   logic [W_IN-1:0] b_eff;
   tri_t            xfer    [N_DIGITS];
   tri_t            interim [N_DIGITS];

   rbr_negate #(.N_DIGITS(N_DIGITS)) u_neg (
      .din(op_b), .invert(sub_en), .dout(b_eff)
   );

   for (genvar k = 0; k < N_DIGITS; k++) begin : g_pos
      digit_t la, lb;
      tri_t   tin;
      digit_t res;

      if (k == 0) begin : g_first
         assign la  = DG_ZERO;
         assign lb  = DG_ZERO;
         assign tin = 2'sd0;
      end else begin : g_rest
         assign la  = op_a[2*(k-1) +: 2];
         assign lb  = b_eff[2*(k-1) +: 2];
         assign tin = xfer[k-1];
      end

      rbr_transfer_cell #(.HAS_LOWER(k != 0)) u_xfer (
         .dig_a(op_a[2*k +: 2]), .dig_b(b_eff[2*k +: 2]),
         .low_a(la), .low_b(lb),
         .xfer(xfer[k]), .interim(interim[k])
      );

      rbr_combine_cell u_comb (
         .interim(interim[k]), .xfer_in(tin), .dig_out(res)
      );

      assign sum[2*k +: 2] = res;
   end

   assign sum[W_OUT-1 -: 2] = dg_encode(xfer[N_DIGITS-1]);
endmodule

// File: rtl/rbr_sd_addsub_chk.sv
module rbr_sd_addsub_chk
   import rbr_pkg::*;
#(
   parameter int N_DIGITS = 8,
   localparam int W_IN  = 2 * N_DIGITS,
   localparam int W_OUT = 2 * (N_DIGITS + 1)
) (
   input logic [W_IN-1:0]  op_a,
   input logic [W_IN-1:0]  op_b,
   input logic             sub_en,
   input logic [W_OUT-1:0] sum
);
   function automatic longint wval(input logic [W_OUT-1:0] v, input int nd);
      longint acc = 0;
      for (int k = nd - 1; k >= 0; k--)
         acc = acc * 2 + longint'(dg_value(v[2*k +: 2]));
      return acc;
   endfunction

   logic all_zero_in;
   logic any_ten_out;
   logic all_zero_out;

   always_comb begin
      all_zero_in = 1'b1;
      for (int k = 0; k < N_DIGITS; k++)
         if (dg_value(op_a[2*k +: 2]) != 0 || dg_value(op_b[2*k +: 2]) != 0)
            all_zero_in = 1'b0;
      any_ten_out  = 1'b0;
      all_zero_out = 1'b1;
      for (int k = 0; k <= N_DIGITS; k++) begin
         if (sum[2*k +: 2] == 2'b10) any_ten_out = 1'b1;
         if (sum[2*k +: 2] != DG_ZERO) all_zero_out = 1'b0;
      end
   end

   always_comb begin
      AST_NO_TEN_CODE: assert (!any_ten_out)
         else $error("result carries code 10");                         // R4
      AST_ZERO_IN_ZERO_OUT: assert (!all_zero_in || all_zero_out)
         else $error("zero operands gave non-canonical result");        // R7
      AST_SELF_SUB_ZERO: assert (!(sub_en && op_a == op_b) || all_zero_out)
         else $error("a minus a not canonical zero");                   // R2
   end

   if (N_DIGITS <= 30) begin : g_val
      longint va, vb, vs;
      always_comb begin
         va = wval(W_OUT'(op_a), N_DIGITS);
         vb = wval(W_OUT'(op_b), N_DIGITS);
         vs = wval(sum, N_DIGITS + 1);
         AST_ADD_VALUE: assert (sub_en || vs == va + vb)
            else $error("sum value wrong");                             // R1
         AST_SUB_VALUE: assert (!sub_en || vs == va - vb)
            else $error("difference value wrong");                      // R2
      end
   end
endmodule

bind rbr_sd_addsub rbr_sd_addsub_chk #(.N_DIGITS(N_DIGITS)) u_chk (
   .op_a(op_a), .op_b(op_b), .sub_en(sub_en), .sum(sum)
);

// File: tb/rbr_sd_addsub_test.sv
module rbr_sd_addsub_test;
   localparam int ND = 4;
   localparam int WI = 2 * ND;
   localparam int WO = 2 * (ND + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [WI-1:0] op_a, op_b;
   logic          sub_en;
   logic [WO-1:0] sum;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rbr_sd_addsub #(.N_DIGITS(ND)) uut (
      .op_a(op_a), .op_b(op_b), .sub_en(sub_en), .sum(sum)
   );

   function automatic int dval(input logic [1:0] d);
      return (d == 2'b00) ? -1 : (d == 2'b11) ? 1 : 0;
   endfunction

   function automatic int wsum(input logic [WO-1:0] v, input int nd);
      int acc = 0;
      for (int k = nd - 1; k >= 0; k--) acc = acc * 2 + dval(v[2*k +: 2]);
      return acc;
   endfunction

   function automatic logic [WI-1:0] canon_zero(input logic [WI-1:0] v);
      logic [WI-1:0] r = v;
      for (int k = 0; k < ND; k++) if (r[2*k +: 2] == 2'b10) r[2*k +: 2] = 2'b01;
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [WI-1:0] a, input logic [WI-1:0] b, input logic s);
      @(posedge clk);
      op_a = a; op_b = b; sub_en = s;
      #1;
   endtask

   function automatic bit has_ten(input logic [WO-1:0] v);
      for (int k = 0; k <= ND; k++) if (v[2*k +: 2] == 2'b10) return 1'b1;
      return 1'b0;
   endfunction

   initial begin
      op_a = '0; op_b = '0; sub_en = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R7: all-zero operands, both zero codes
      apply({ND{2'b01}}, {ND{2'b10}}, 1'b0);
      check(sum == {(ND+1){2'b01}}, "R7", sum, {(ND+1){2'b01}});
      apply({ND{2'b10}}, {ND{2'b01}}, 1'b1);
      check(sum == {(ND+1){2'b01}}, "R7", sum, {(ND+1){2'b01}});

      // R1, R2, R4: exhaustive sweep
      for (int s = 0; s < 2; s++)
         for (int a = 0; a < (1 << WI); a++)
            for (int b = 0; b < (1 << WI); b++) begin
               int exp;
               apply(WI'(a), WI'(b), s[0]);
               exp = s ? wsum(WO'(a), ND) - wsum(WO'(b), ND)
                       : wsum(WO'(a), ND) + wsum(WO'(b), ND);
               check(wsum(sum, ND + 1) == exp, s ? "R2" : "R1",
                     wsum(sum, ND + 1), exp);
               check(!has_ten(sum), "R4", sum, 0);
            end

      // R3: code 10 and 01 interchangeable
      for (int a = 0; a < (1 << WI); a++) begin
         logic [WO-1:0] r0;
         logic [WI-1:0] b = WI'(a * 37 + 11);
         apply(WI'(a), b, a[0]);
         r0 = sum;
         apply(canon_zero(WI'(a)), canon_zero(b), a[0]);
         check(sum == r0, "R3", sum, r0);
      end

      // R6: subtract equals add of inverted operand
      for (int b = 0; b < (1 << WI); b++) begin
         logic [WO-1:0] r0;
         logic [WI-1:0] a = WI'(b * 91 + 5);
         apply(a, WI'(b), 1'b1);
         r0 = sum;
         apply(a, ~WI'(b), 1'b0);
         check(sum == r0, "R6", sum, r0);
      end

      // R5: locality window of three positions
      for (int j = 0; j < ND; j++)
         for (int v = 0; v < 64; v++) begin
            logic [WO-1:0] r0, mask;
            logic [WI-1:0] a = WI'(v * 53 + 7), b = WI'(v * 29 + 3), a2;
            a2 = a;
            a2[2*j +: 2] = ~a[2*j +: 2];
            apply(a, b, v[0]);
            r0 = sum;
            apply(a2, b, v[0]);
            mask = '0;
            for (int k = 0; k <= ND; k++)
               if (k < j || k > j + 2) mask[2*k +: 2] = 2'b11;
            check((sum & mask) == (r0 & mask), "R5", sum & mask, r0 & mask);
         end

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 190000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) check(1'b0, "watchdog", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule